// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Checker

This block computes a cyclic redundancy check one bit per clock with a remainder register that has one flop per degree of the generator polynomial. Bits arrive most significant first on a serial input with a valid strobe and a last-bit marker. The polynomial and its degree are parameters. The default generator is x^3 + x^2 + 1.

In transmit mode the message bits are passed through to the serial output unchanged. The division is carried out over the message extended by degree-many zero bits. The resulting remainder is then shifted out right after the final message bit, so the frame on the wire divides evenly. In receive mode the whole frame, including the check bits, is divided. A verdict is raised when the last bit has been taken in: the frame is good exactly when the remainder is zero. Only the message part of the frame is forwarded, and the trailing check bits are removed.

The direction is chosen per frame by a mode input, and that input is sampled with the first bit of each frame.

Top module: `serial_crc_codec`

## Requirements
- R1: After reset, and at the first accepted bit of every frame, the DEG-bit remainder starts from zero. Each accepted bit shifts the register left with the new bit entering at position 0. The generator's low DEG coefficients are XORed in whenever the bit shifted out of position DEG-1 is one. After reset `out_valid` and `done` are low and `in_ready` is high.
- R2: In transmit mode (`rx_mode` = 0 at the first bit), every accepted message bit appears unchanged on `out_bit`, with `out_valid` high, in the cycle after it is accepted.
- R3: In transmit mode the check value is (message · x^DEG) mod G. It is emitted most significant bit first on DEG consecutive cycles that immediately follow the last message bit on the output. With the defaults, message 0xD6B5 gives check value 3'b101 and the frame 0x6B5AD.
- R4: In transmit mode `in_ready` drops for exactly DEG cycles after the last message bit is accepted. A bit offered during that window is not taken, and it is accepted intact once `in_ready` returns.
- R5: In transmit mode `done` pulses together with the last check bit on the output, and `crc_ok` stays low.
- R6: In receive mode (`rx_mode` = 1 at the first bit), `done` pulses in the cycle after the last frame bit is accepted. With it, `crc_ok` is high exactly when the frame divided by G leaves a zero remainder.
- R7: In receive mode `out_valid` delivers only the first N-DEG bits of an N-bit frame, in order, and never a check bit. The last data bit appears in the same cycle as `done`.
- R8: A frame in which any single bit of a valid codeword is inverted is reported with `crc_ok` low.
- R9: A change of `rx_mode` after the first bit of a frame has no effect on that frame.
- R10: Cycles with `in_valid` low in the middle of a frame leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 1 | 1 = check a received frame, 0 = generate; sampled with first bit |
| in_bit | input | 1 | Serial input bit, most significant first |
| in_valid | input | 1 | `in_bit` is offered this cycle |
| in_last | input | 1 | Marks the final bit of the message (transmit) or frame (receive) |
| in_ready | output | 1 | Input bit is taken when high together with `in_valid` |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | `out_bit` carries a frame bit (transmit) or data bit (receive) |
| done | output | 1 | One-cycle end-of-frame pulse |
| crc_ok | output | 1 | Receive verdict, valid while `done` is high |

## Verification
The two functions that share a cycle are these: in receive mode, the release of the last data bit from the tail-drop line and the verdict pulse; in transmit mode, the last check bit and `done`. Every receive frame in the exhaustive sweep over all 9-bit frames provokes the first case. It is judged by comparing the cycle of the final `out_valid` with the cycle of `done`, both measured from the acceptance cycle of the last input bit. Back-to-back transmit frames also put the next frame's first bit on the input while the check value is still being emitted. The combined output stream is then compared with a long-division model in the bench.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BODY = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

endpackage

// File: rtl/serdiv_step.sv
// One division step: shift left, new bit enters at the bottom, and the
// generator taps are XORed in when the outgoing top bit is one.
module serdiv_step #(
    parameter int           DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic [DEG-1:0] rem_in,
    input  logic           bit_in,
    output logic [DEG-1:0] rem_out
);
    logic fb;
    assign fb = rem_in[DEG-1];

    for (genvar i = 0; i < DEG; i++) begin : g_tap
        logic shifted;
        if (i == 0) begin : g_lsb
            assign shifted = bit_in;
        end else begin : g_mid
            assign shifted = rem_in[i-1];
        end
        if (POLY[i]) begin : g_xor
            assign rem_out[i] = shifted ^ fb;
        end else begin : g_pass
            assign rem_out[i] = shifted;
        end
    end
endmodule

// File: rtl/serdiv_flush.sv
// DEG zero-bit division steps chained in one cycle (the augmentation).
module serdiv_flush #(
    parameter int           DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic [DEG-1:0] rem_in,
    output logic [DEG-1:0] rem_out
);
    logic [DEG:0][DEG-1:0] chain;
    assign chain[0] = rem_in;

    for (genvar k = 0; k < DEG; k++) begin : g_zero
        serdiv_step #(.DEG(DEG), .POLY(POLY)) u_step (
            .rem_in (chain[k]),
            .bit_in (1'b0),
            .rem_out(chain[k+1])
        );
    end

    assign rem_out = chain[DEG];
endmodule

// File: rtl/tail_strip.sv
// Receive-side delay line: holds the newest DEG bits so that the check
// bits at the end of a frame are never forwarded.
module tail_strip #(
    parameter int DEG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic bit_in,
    input  logic last,
    output logic out_bit,
    output logic out_valid
);
    localparam int FW = $clog2(DEG + 1);

    typedef struct packed {
        logic [DEG-1:0] line;
        logic [FW-1:0]  fill;
        logic           obit;
        logic           ovld;
    } strip_t;

    strip_t q, d;

    always_comb begin
        d      = q;
        d.ovld = 1'b0;
        if (push) begin
            d.ovld = (q.fill == FW'(DEG));
            d.obit = q.line[DEG-1];
            d.line = {q.line[DEG-2:0], bit_in};
            if (last) begin
                d.fill = '0;
            end else if (q.fill != FW'(DEG)) begin
                d.fill = q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_bit   = q.obit;
    assign out_valid = q.ovld;
endmodule

// File: rtl/serial_crc_codec.sv
module serial_crc_codec
    import crc_pkg::*;
#(
    parameter int           DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mode,
    input  logic in_bit,
    input  logic in_valid,
    input  logic in_last,
    output logic in_ready,
    output logic out_bit,
    output logic out_valid,
    output logic done,
    output logic crc_ok
);
    localparam int CW = (DEG > 1) ? $clog2(DEG) : 1;

    typedef struct packed {
        phase_e         phase;
        logic           rx;
        logic [DEG-1:0] rem;
        logic [CW-1:0]  cnt;
        logic           obit;
        logic           ovld;
        logic           done;
        logic           ok;
    } codec_t;

    codec_t q, d;

    logic           accept;
    logic           rx_now;
    logic [DEG-1:0] base;
    logic [DEG-1:0] stepped;
    logic [DEG-1:0] flushed;
    logic           s_bit;
    logic           s_vld;

    assign in_ready = (q.phase != PH_EMIT);
    assign accept   = in_valid & in_ready;
    assign rx_now   = (q.phase == PH_IDLE) ? rx_mode : q.rx;
    assign base     = (q.phase == PH_IDLE) ? '0 : q.rem;

    serdiv_step #(.DEG(DEG), .POLY(POLY)) u_step (
        .rem_in (base),
        .bit_in (in_bit),
        .rem_out(stepped)
    );

    serdiv_flush #(.DEG(DEG), .POLY(POLY)) u_flush (
        .rem_in (stepped),
        .rem_out(flushed)
    );

    tail_strip #(.DEG(DEG)) u_strip (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept & rx_now),
        .bit_in   (in_bit),
        .last     (in_last),
        .out_bit  (s_bit),
        .out_valid(s_vld)
    );

    always_comb begin
        d      = q;
        d.ovld = 1'b0;
        d.done = 1'b0;
        d.ok   = 1'b0;
        if (q.phase == PH_EMIT) begin
            d.obit = q.rem[DEG-1];
            d.ovld = 1'b1;
            d.rem  = {q.rem[DEG-2:0], 1'b0};
            if (q.cnt == CW'(DEG - 1)) begin
                d.phase = PH_IDLE;
                d.cnt   = '0;
                d.done  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (accept) begin
            d.rx = rx_now;
            if (rx_now) begin
                if (in_last) begin
                    d.phase = PH_IDLE;
                    d.rem   = '0;
                    d.done  = 1'b1;
                    d.ok    = (stepped == '0);
                end else begin
                    d.phase = PH_BODY;
                    d.rem   = stepped;
                end
            end else begin
                d.obit = in_bit;
                d.ovld = 1'b1;
                if (in_last) begin
                    d.phase = PH_EMIT;
                    d.rem   = flushed;
                    d.cnt   = '0;
                end else begin
                    d.phase = PH_BODY;
                    d.rem   = stepped;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ovld | s_vld;
    assign out_bit   = s_vld ? s_bit : q.obit;
    assign done      = q.done;
    assign crc_ok    = q.ok;
endmodule

// File: rtl/serial_crc_sva.sv
module serial_crc_sva #(
    parameter int DEG = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rx_now,
    input logic in_bit,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic out_bit,
    input logic out_valid,
    input logic done,
    input logic crc_ok
);
    localparam int RW = $clog2(DEG + 2) + 1;

    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (in_ready) begin
            run <= '0;
        end else if (run != RW'(DEG + 1)) begin
            run <= run + 1'b1;
        end
    end

    // R2: transmit bits pass through one cycle later
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !rx_now) |=> (out_valid && out_bit == $past(in_bit)));

    // R4: input is held off right after the last transmit bit
    a_r4_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !rx_now) |=> !in_ready);

    // R4: the hold-off never lasts longer than DEG cycles
    a_r4_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (run < RW'(DEG)));

    // R6: receive verdict follows the last frame bit
    a_r6_verdict_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && rx_now) |=> done);

    // R6: pass flag only appears with the end-of-frame pulse
    a_r6_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done);
endmodule

bind serial_crc_codec serial_crc_sva #(.DEG(DEG)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_now   (rx_now),
    .in_bit   (in_bit),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .out_bit  (out_bit),
    .out_valid(out_valid),
    .done     (done),
    .crc_ok   (crc_ok)
);

// File: tb/tb_serial_crc_codec.sv
module tb_serial_crc_codec;
    localparam int G_DEG = 3;
    localparam logic [63:0] G_POLY = 64'd13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_mode = 1'b0;
    logic in_bit = 1'b0;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic in_ready, out_bit, out_valid, done, crc_ok;

    serial_crc_codec #(.DEG(3), .POLY(4'b1101)) dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .in_bit(in_bit),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_bit(out_bit), .out_valid(out_valid), .done(done), .crc_ok(crc_ok)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // capture of outputs, sampled at the falling edge
    logic [63:0] capv;
    int ncap, ndone, nlow, done_cyc, last_acc;
    logic done_ok;
    int cap_cyc [0:63];

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                capv = {capv[62:0], out_bit};
                if (ncap < 64) cap_cyc[ncap] = cyc;
                ncap++;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
                done_ok = crc_ok;
            end
            if (!in_ready) nlow++;
        end
    end

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            report();
        end
    end

    task automatic check(input bit cond, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // long division by the generator, MSB first
    function automatic logic [2:0] mod_g(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= G_DEG; i--) begin
            if (v[i]) v = v ^ (G_POLY << (i - G_DEG));
        end
        return v[2:0];
    endfunction

    task automatic clear_cap;
        capv = '0; ncap = 0; ndone = 0; nlow = 0; done_cyc = -1; done_ok = 1'b0;
    endtask

    // called at a falling edge; returns at the falling edge after the last accept
    task automatic send(input logic rx, input logic [63:0] bits, input int n,
                        input int gap, input bit flip);
        for (int i = n - 1; i >= 0; i--) begin
            if (gap > 0 && i != n - 1) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            in_valid = 1'b1;
            in_bit   = bits[i];
            in_last  = (i == 0);
            rx_mode  = (flip && i != n - 1) ? ~rx : rx;
            while (!in_ready) @(negedge clk);
            if (i == 0) last_acc = cyc;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int k);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    task automatic tx_frame(input logic [63:0] msg, input int n, input int gap,
                            input bit flip, input string tag);
        logic [63:0] exp;
        exp = (msg << 3) | 64'(mod_g(msg << 3, n + 3));
        clear_cap();
        send(1'b0, msg, n, gap, flip);
        idle(2 * G_DEG + 3);
        check(ncap == n + 3 && capv == exp, tag, capv, exp);
        check(cap_cyc[n-1] == last_acc + 1 && cap_cyc[n+2] == last_acc + 4,
              "R3 check bits consecutive after message", 64'(cap_cyc[n+2]), 64'(last_acc + 4));
        check(nlow == G_DEG, "R4 hold-off length", 64'(nlow), 64'(G_DEG));
        check(ndone == 1 && done_cyc == last_acc + 4 && !done_ok,
              "R5 transmit done with last check bit", 64'(done_cyc), 64'(last_acc + 4));
    endtask

    task automatic rx_frame(input logic [63:0] fr, input int n, input int gap,
                            input bit flip, input string tag);
        logic good;
        good = (mod_g(fr, n) == 3'd0);
        clear_cap();
        send(1'b1, fr, n, gap, flip);
        idle(2 * G_DEG + 3);
        check(ndone == 1 && done_cyc == last_acc + 1 && done_ok == good,
              tag, 64'(done_ok), 64'(good));
        check(ncap == n - 3 && capv == (fr >> 3), "R7 check bits dropped", capv, fr >> 3);
        check(cap_cyc[ncap-1] == done_cyc, "R7 last data bit with done",
              64'(cap_cyc[ncap-1]), 64'(done_cyc));
    endtask

    initial begin
        clear_cap();
        last_acc = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && !done && in_ready, "R1 reset outputs",
              {61'd0, out_valid, done, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: default worked example
        check(mod_g(64'hD6B5 << 3, 19) == 3'b101, "R3 model check value",
              64'(mod_g(64'hD6B5 << 3, 19)), 64'd5);
        clear_cap();
        send(1'b0, 64'hD6B5, 16, 0, 1'b0);
        idle(9);
        check(capv == 64'h6B5AD && ncap == 19, "R3 default frame", capv, 64'h6B5AD);
        rx_frame(64'h6B5AD, 19, 0, 1'b0, "R6 default frame passes");

        // R1 R2 R3: all 6-bit messages
        for (int m = 0; m < 64; m++) tx_frame(64'(m), 6, 0, 1'b0, "R2 R1 transmit frame");

        // R6 R7: every 9-bit frame
        for (int f = 0; f < 512; f++) rx_frame(64'(f), 9, 0, 1'b0, "R6 receive verdict");

        // R8: single-bit errors on valid codewords
        for (int m = 0; m < 16; m++) begin
            logic [63:0] cw;
            cw = (64'(m) << 3) | 64'(mod_g(64'(m) << 3, 9));
            rx_frame(cw, 9, 0, 1'b0, "R8 clean codeword passes");
            for (int p = 0; p < 9; p++) begin
                clear_cap();
                send(1'b1, cw ^ (64'd1 << p), 9, 0, 1'b0);
                idle(9);
                check(ndone == 1 && !done_ok, "R8 flipped bit rejected", 64'(done_ok), 64'd0);
            end
        end

        // R9: mode changes mid-frame are ignored
        tx_frame(64'h2D, 6, 0, 1'b1, "R9 transmit with mode toggling");
        rx_frame(64'h6B5AD, 19, 0, 1'b1, "R9 receive with mode toggling");

        // R10: idle gaps inside frames
        tx_frame(64'h35, 6, 2, 1'b0, "R10 transmit with gaps");
        rx_frame(64'h6B5AD, 19, 3, 1'b0, "R10 receive with gaps");

        // R4: next frame offered during check emission
        begin
            logic [63:0] ea, eb;
            ea = (64'h2B << 3) | 64'(mod_g(64'h2B << 3, 9));
            eb = (64'h1C << 3) | 64'(mod_g(64'h1C << 3, 9));
            clear_cap();
            send(1'b0, 64'h2B, 6, 0, 1'b0);
            send(1'b0, 64'h1C, 6, 0, 1'b0);
            idle(9);
            check(ncap == 18 && capv == ((ea << 9) | eb), "R4 back-to-back frames",
                  capv, (ea << 9) | eb);
            check(nlow == 2 * G_DEG, "R4 offered bit held", 64'(nlow), 64'(2 * G_DEG));
        end

        report();
    end
endmodule